// File: doc/BRIEF.md
# Bit-Operation Program Search Engine

This block searches, one candidate per clock, for a short program of single-bit-step operations that turns a captured source word into a captured goal word. A program is a packed word of 2-bit operation codes. Each code drives one stage of a combinational chain. A stage either passes its word through, inverts every bit, shifts the word left by one place, or shifts it right by one place.

A pulse on `start` captures the source and goal words and sets the candidate counter to zero. The counter then walks through every packed program in ascending numeric order. The first program whose chain result equals the goal stops the search with `done` and `found` high, and that program stays on `prog`. If no program matches, the search ends on the all-ones candidate with `done` high and `found` low.

The results stay valid until the next accepted start. While a search is running, the block ignores any further start pulses.

Top module: `bitprog_search`

## Requirements
- R1: Operation codes are 0 = pass through unchanged, 1 = invert every bit, 2 = shift left by one, 3 = shift right by one.
- R2: Stage i takes its code from program bits [2i+1:2i], and stage 0 acts first on the source word. The candidate number is therefore the sum of code_i·4^i.
- R3: Shift left moves each bit up one place, fills bit 0 with 0, and drops the old most significant bit.
- R4: Shift right moves each bit down one place, fills the most significant bit with 0, and drops the old bit 0.
- R5: A candidate matches only when the chain result equals the goal word in every bit.
- R6: A start accepted while idle captures the source and goal and clears `done` and `found`. It begins with candidate 0 and tests one candidate per clock, so a hit on candidate k raises `done` k+1 clocks after the capturing edge.
- R7: The search stops at the lowest-numbered matching candidate, raises `done` and `found` together, and shows that candidate on `prog`.
- R8: All 4^DEPTH candidates are tried. When none matches, `done` rises 4^DEPTH clocks after the capturing edge, with `found` low and `prog` all ones.
- R9: A start pulse during a running search has no effect on its inputs, its timing or its result.
- R10: After a search ends, `done`, `found` and `prog` hold their values until the next start, and that start clears `done` one clock later.
- R11: After reset, `done`, `found` and `prog` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search; taken only while idle |
| src_word | input | WIDTH | Word fed to the first stage, captured on start |
| goal_word | input | WIDTH | Word to reach, captured on start |
| done | output | 1 | Search finished |
| found | output | 1 | A matching program was found |
| prog | output | 2*DEPTH | Current candidate; the result once done |

## Verification
The hardest case to reach is a full search that runs out of candidates. Only a goal that no program can produce gets there. The stimulus uses source 00000 and goal 10101. Every shift adds at most one bit transition and four operations cannot build four transitions, so all 256 candidates fail. The same long run also covers the ignored-start requirement: a start pulse carrying source and goal words that would match at once is sent midway through, and the run must still end at the exhaustion time with `found` low.

// File: rtl/bitsrch_pkg.sv
// Package: shared operation codes and controller state encoding.
// Assumes: the code values match the program packing used by every stage.
package bitsrch_pkg;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_INV  = 2'd1,
        OP_SHL  = 2'd2,
        OP_SHR  = 2'd3
    } op_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } srch_state_t;

endpackage

// File: rtl/bitop_stage.sv
// Module: bitop_stage
// Applies one operation, selected by a 2-bit code, to a word.
// Assumes: WIDTH >= 2, purely combinational.
module bitop_stage
    import bitsrch_pkg::*;
#(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] din,
    input  logic [1:0]       op,
    output logic [WIDTH-1:0] dout
);

    op_t op_e;
    assign op_e = op_t'(op);

    // Select the transformed word for this stage.
    always_comb begin
        unique case (op_e)
            OP_PASS: dout = din;
            OP_INV:  dout = ~din;
            OP_SHL:  dout = {din[WIDTH-2:0], 1'b0};
            OP_SHR:  dout = {1'b0, din[WIDTH-1:1]};
            default: dout = din;
        endcase
    end

    // Check fill bits of the shifts against the input side.
    always_comb begin
        if (op_e == OP_SHL) begin
            AST_SHL_FILL: assert (dout[0] == 1'b0 && dout[WIDTH-1] == din[WIDTH-2]) else $error("shl fill"); // R3
        end
        if (op_e == OP_SHR) begin
            AST_SHR_FILL: assert (dout[WIDTH-1] == 1'b0 && dout[0] == din[1]) else $error("shr fill"); // R4
        end
        if (op_e == OP_INV) begin
            AST_INV_BITS: assert ((dout ^ din) == {WIDTH{1'b1}}) else $error("inv"); // R1
        end
    end

endmodule

// File: rtl/bitop_chain.sv
// Module: bitop_chain
// Chains DEPTH operation stages. Stage i reads program bits [2i+1:2i],
// and stage 0 sees the source word first.
// Assumes: program stays stable for the cycle the result is used.
module bitop_chain #(
    parameter int WIDTH = 5,
    parameter int DEPTH = 4,
    localparam int PW   = 2 * DEPTH
) (
    input  logic [WIDTH-1:0] src,
    input  logic [PW-1:0]    program_word,
    output logic [WIDTH-1:0] result
);

    logic [WIDTH-1:0] link [DEPTH+1];

    assign link[0] = src;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        bitop_stage #(
            .WIDTH(WIDTH)
        ) u_stage (
            .din  (link[g]),
            .op   (program_word[2*g+1:2*g]),
            .dout (link[g+1])
        );
    end

    assign result = link[DEPTH];

endmodule

// File: rtl/srch_ctrl.sv
// Module: srch_ctrl
// Search controller: captures operands on start, steps the candidate
// counter one per clock, and stops on the first hit or after the last
// candidate. Starts are ignored while running.
// Assumes: hit is the combinational compare for the current candidate.
module srch_ctrl
    import bitsrch_pkg::*;
#(
    parameter int WIDTH = 5,
    parameter int DEPTH = 4,
    localparam int PW   = 2 * DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] src_word,
    input  logic [WIDTH-1:0] goal_word,
    input  logic             hit,
    output logic [WIDTH-1:0] src_q,
    output logic [WIDTH-1:0] goal_q,
    output logic [PW-1:0]    cand_q,
    output logic             busy,
    output logic             done,
    output logic             found
);

    srch_state_t state_q;
    logic        accept;
    logic        last_cand;

    assign busy      = (state_q == ST_RUN);
    assign accept    = (state_q == ST_IDLE) && start;
    assign last_cand = &cand_q;

    // State register: idle until an accepted start, run until hit or exhaustion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (accept) begin
            state_q <= ST_RUN;
        end else if (busy && (hit || last_cand)) begin
            state_q <= ST_IDLE;
        end
    end

    // Operand capture on an accepted start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            goal_q <= '0;
        end else if (accept) begin
            src_q  <= src_word;
            goal_q <= goal_word;
        end
    end

    // Candidate counter: cleared on start, advanced while no hit and not last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= '0;
        end else if (accept) begin
            cand_q <= '0;
        end else if (busy && !hit && !last_cand) begin
            cand_q <= cand_q + 1'b1;
        end
    end

    // Result flags: cleared on start, set at the end of a search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            found <= 1'b0;
        end else if (accept) begin
            done  <= 1'b0;
            found <= 1'b0;
        end else if (busy && hit) begin
            done  <= 1'b1;
            found <= 1'b1;
        end else if (busy && last_cand) begin
            done  <= 1'b1;
            found <= 1'b0;
        end
    end

    AST_FOUND_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> done) else $error("found without done"); // R7

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !hit && !last_cand) |=> (busy && cand_q == $past(cand_q) + 1'b1)) else $error("step"); // R6

    AST_HIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hit) |=> (done && found && !busy && cand_q == $past(cand_q))) else $error("hit stop"); // R7

    AST_EXHAUST_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !hit && last_cand) |=> (done && !found && !busy)) else $error("exhaust"); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(src_q) && $stable(goal_q))) else $error("start ignored"); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && done && !start) |=> ($stable(done) && $stable(found) && $stable(cand_q))) else $error("hold"); // R10

    AST_RUN_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done) else $error("done while running"); // R6

endmodule

// File: rtl/bitprog_search.sv
// Module: bitprog_search (top)
// Searches every packed program of DEPTH bit operations in ascending
// order for the first one that maps the captured source to the goal.
// Assumes: synchronous active-low reset, single clock domain.
module bitprog_search #(
    parameter int WIDTH = 5,
    parameter int DEPTH = 4,
    localparam int PW   = 2 * DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] src_word,
    input  logic [WIDTH-1:0] goal_word,
    output logic             done,
    output logic             found,
    output logic [PW-1:0]    prog
);

    logic [WIDTH-1:0] src_q;
    logic [WIDTH-1:0] goal_q;
    logic [PW-1:0]    cand_q;
    logic [WIDTH-1:0] chain_out;
    logic             hit;
    logic             busy;

    bitop_chain #(
        .WIDTH(WIDTH),
        .DEPTH(DEPTH)
    ) u_chain (
        .src          (src_q),
        .program_word (cand_q),
        .result       (chain_out)
    );

    // Full-word equality between the chain result and the goal.
    assign hit = (chain_out == goal_q);

    srch_ctrl #(
        .WIDTH(WIDTH),
        .DEPTH(DEPTH)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .src_word  (src_word),
        .goal_word (goal_word),
        .hit       (hit),
        .src_q     (src_q),
        .goal_q    (goal_q),
        .cand_q    (cand_q),
        .busy      (busy),
        .done      (done),
        .found     (found)
    );

    assign prog = cand_q;

    AST_FOUND_MEANS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !busy) |-> (chain_out == goal_q)) else $error("found but no match"); // R5

endmodule

// File: tb/sim_bitprog_search.sv
module sim_bitprog_search;

    localparam int W    = 5;
    localparam int D    = 4;
    localparam int PW   = 2 * D;
    localparam int NCND = 4 ** D;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  src_word = '0;
    logic [W-1:0]  goal_word = '0;
    logic          done;
    logic          found;
    logic [PW-1:0] prog;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    bitprog_search #(.WIDTH(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_word(src_word), .goal_word(goal_word),
        .done(done), .found(found), .prog(prog)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model of the chain from the requirements (R1..R4, R2 packing).
    function automatic logic [W-1:0] model_run(input logic [W-1:0] s, input logic [PW-1:0] p);
        logic [W-1:0] v = s;
        for (int i = 0; i < D; i++) begin
            case (p[2*i +: 2])
                2'd0: v = v;
                2'd1: v = ~v;
                2'd2: v = {v[W-2:0], 1'b0};
                default: v = {1'b0, v[W-1:1]};
            endcase
        end
        return v;
    endfunction

    // Lowest matching candidate, or -1 (R5, R7).
    function automatic int model_search(input logic [W-1:0] s, input logic [W-1:0] g);
        for (int k = 0; k < NCND; k++) begin
            if (model_run(s, PW'(k)) == g) return k;
        end
        return -1;
    endfunction

    // Start a search and count clocks until done; optional mid-run restart pulse.
    task automatic run_search(input logic [W-1:0] s, input logic [W-1:0] g,
                              input int poke_at, input logic [W-1:0] ps, input logic [W-1:0] pg,
                              output int lat);
        @(negedge clk);
        src_word = s; goal_word = g; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < NCND + 50) begin
            if (lat == poke_at) begin
                src_word = ps; goal_word = pg; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        if (!done) check(1'b0, "R8", "watchdog on search", lat, NCND);
    endtask

    task automatic t_found(input logic [W-1:0] s, input logic [W-1:0] g,
                           input int exp_k, input string req);
        int lat;
        run_search(s, g, -1, '0, '0, lat);
        check(found == 1'b1, req, "found", int'(found), 1);
        check(int'(prog) == exp_k, req, "prog", int'(prog), exp_k);
        check(lat == exp_k + 1, "R6", "latency", lat, exp_k + 1);
        check(model_run(s, prog) == g, "R5", "program reproduces goal", int'(model_run(s, prog)), int'(g));
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R11", "done after reset", int'(done), 0);
        check(found == 1'b0, "R11", "found after reset", int'(found), 0);
        check(prog == '0, "R11", "prog after reset", int'(prog), 0);
    endtask

    task automatic t_fail_and_ignore();
        int lat;
        // Source 0 with goal 10101 is unreachable; a mid-run start with an easy match must be ignored (R9).
        run_search(5'b00000, 5'b10101, 10, 5'b11111, 5'b11111, lat);
        check(model_search(5'b00000, 5'b10101) == -1, "R8", "model unreachable", model_search(5'b00000, 5'b10101), -1);
        check(found == 1'b0, "R8", "found on exhaustion", int'(found), 0);
        check(prog == '1, "R8", "prog on exhaustion", int'(prog), NCND - 1);
        check(lat == NCND, "R9", "latency with ignored start", lat, NCND);
    endtask

    task automatic t_hold();
        int lat;
        logic [PW-1:0] p0;
        run_search(5'b11111, 5'b10000, -1, '0, '0, lat);
        p0 = prog;
        repeat (20) @(negedge clk);
        check(done && found, "R10", "flags held", int'({done, found}), 3);
        check(prog == p0, "R10", "prog held", int'(prog), int'(p0));
        src_word = 5'b00000; goal_word = 5'b10101; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R10", "done cleared by start", int'(done), 0);
        check(found == 1'b0, "R6", "found cleared by start", int'(found), 0);
        while (!done) @(negedge clk);
    endtask

    task automatic t_patterns();
        logic [W-1:0] ps [4] = '{5'b10011, 5'b01100, 5'b00111, 5'b11010};
        logic [W-1:0] pg [4] = '{5'b00110, 5'b11001, 5'b11100, 5'b00101};
        for (int i = 0; i < 4; i++) begin
            int k;
            int lat;
            k = model_search(ps[i], pg[i]);
            run_search(ps[i], pg[i], -1, '0, '0, lat);
            check(int'(found) == (k >= 0 ? 1 : 0), "R7", "pattern found", int'(found), (k >= 0 ? 1 : 0));
            if (k >= 0) begin
                check(int'(prog) == k, "R7", "pattern lowest prog", int'(prog), k);
                check(lat == k + 1, "R6", "pattern latency", lat, k + 1);
            end else begin
                check(lat == NCND, "R8", "pattern exhaust latency", lat, NCND);
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_found(5'b10110, 5'b10110, 0, "R1");   // pass-through is candidate 0
        t_found(5'b01010, 5'b10101, 1, "R1");   // invert is code 1
        t_found(5'b10000, 5'b00000, 2, "R3");   // shift left drops MSB
        t_found(5'b10000, 5'b01000, 3, "R4");   // shift right fills MSB with 0
        t_found(5'b11111, 5'b10000, 7, "R2");   // shr at stage 0 then invert at stage 1
        t_found(5'b11111, 5'b10000, model_search(5'b11111, 5'b10000), "R7");
        t_fail_and_ignore();
        t_hold();
        t_patterns();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule